// File: doc/BRIEF.md
# Vulnerability-Ranked Floating-Point Pipeline Allocator

This block hands out shared floating-point pipelines to requesting cores. Each pipeline has a measured error-rate figure, loaded from outside. When a new set of figures is loaded, the block rebuilds an ordering of the pipelines from least to most error-prone. A core asks for a pipeline of a given operation type, in accurate or approximate mode, with an error-rate limit attached. The block walks the ordering and grants the first pipeline that meets three conditions: it is idle, it supports the operation type, and, for an approximate request, its error rate is under the limit. That pipeline is marked busy and its operating-mode output is set to the requested mode.

Pipelines return to the pool through a separate release input. When no pipeline qualifies, the request is simply not accepted. The requester holds it until a release makes a candidate available.

A small state machine controls the block. The states are:

- `S_EMPTY`: the state after reset; no figures have been loaded yet.
- `S_SORT`: a single cycle in which the ordering is written from the latched figures.
- `S_SERVE`: requests are accepted.

The transitions are:

- `load`: from any state to `S_SORT` whenever `metric_load` is high.
- `sorted`: from `S_SORT` to `S_SERVE` on the next cycle when no further load arrives.
- `hold`: the block stays in `S_EMPTY` or `S_SERVE` while there is no load.

Top module: `fpa_alloc_top`

## Requirements
- R1: After a load, candidates are checked in ascending order of error-rate figure. Equal figures are checked lower pipeline index first. Figure p occupies bits [p*METRIC_W +: METRIC_W] of `metric_in`.
- R2: An accepted request is granted the first candidate in that order that is idle and otherwise eligible. Busy pipelines are skipped.
- R3: A pipeline is eligible only if bit p*NUM_OPS+op of `cap_mask` is 1. Here op is the requested operation type.
- R4: An approximate request (`req_approx`=1) may take a pipeline only when that pipeline's figure is strictly less than `req_thresh`. An accurate request ignores the limit.
- R5: In the cycle after acceptance (`req_valid` and `req_ready` both high at an edge), `grant_valid` is 1 for one cycle, `grant_idx` carries the pipeline index, and that pipeline's `pipe_busy` bit is 1.
- R6: On a grant, `pipe_approx[p]` takes the request's mode (1 = approximate, 0 = accurate). It holds that value until the next grant of that pipeline.
- R7: While no pipeline qualifies, `req_ready` stays 0 and a held request waits. It is accepted once a release frees a qualifying pipeline.
- R8: `release_valid` clears `pipe_busy[release_idx]` at the next edge. Releasing an idle pipeline changes no output.
- R9: After reset, `pipe_busy`, `pipe_approx` and `grant_valid` are 0. `req_ready` stays 0 until figures have been loaded.
- R10: `req_ready` is 0 in the cycle `metric_load` is high and in the ranking cycle that follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| metric_load | input | 1 | Latch new error-rate figures and rebuild the ordering |
| metric_in | input | NUM_PIPES*METRIC_W | Error-rate figure per pipeline |
| cap_mask | input | NUM_PIPES*NUM_OPS | Operation-type support per pipeline |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted at this edge |
| req_op | input | OP_W | Requested operation type |
| req_approx | input | 1 | 1 = approximate mode, 0 = accurate |
| req_thresh | input | METRIC_W | Error-rate limit for approximate requests |
| grant_valid | output | 1 | Grant strobe |
| grant_idx | output | IDX_W | Granted pipeline index |
| release_valid | input | 1 | Release strobe |
| release_idx | input | IDX_W | Pipeline to release |
| pipe_busy | output | NUM_PIPES | Busy flag per pipeline |
| pipe_approx | output | NUM_PIPES | Operating mode per pipeline |

## Verification
Several properties are checked by assertions on every cycle:

- the stored ordering is non-decreasing in figure whenever the block serves;
- a grant always targets an idle, capable pipeline that is under the limit when the request is approximate;
- the granted pipeline shows busy together with the strobe, and its mode matches the request;
- readiness never appears outside `S_SERVE`.

Other properties are visible only from the bench's scenarios. These include:

- that the candidate chosen is the lowest-ranked eligible one, including tie-breaks;
- that a held request is accepted only after a release;
- that a release of an idle pipeline has no effect;
- that readiness drops across a reload.

// File: rtl/fpa_pkg.sv
package fpa_pkg;
    typedef enum logic [1:0] {
        S_EMPTY = 2'd0,
        S_SORT  = 2'd1,
        S_SERVE = 2'd2
    } fpa_state_e;
endpackage

// File: rtl/fpa_rank_sort.sv
module fpa_rank_sort #(
    parameter int NUM_PIPES = 8,
    parameter int METRIC_W  = 8,
    parameter int IDX_W     = 3
) (
    input  logic [NUM_PIPES*METRIC_W-1:0] metrics,
    output logic [NUM_PIPES*IDX_W-1:0]    order
);
    // Each pipeline's slot is the number of pipelines that outrank it.
    always_comb begin
        order = '0;
        for (int i = 0; i < NUM_PIPES; i++) begin
            int cnt;
            cnt = 0;
            for (int j = 0; j < NUM_PIPES; j++) begin
                if ((metrics[j*METRIC_W +: METRIC_W] < metrics[i*METRIC_W +: METRIC_W]) ||
                    ((metrics[j*METRIC_W +: METRIC_W] == metrics[i*METRIC_W +: METRIC_W]) && (j < i)))
                    cnt = cnt + 1;
            end
            order[cnt*IDX_W +: IDX_W] = IDX_W'(i);
        end
    end
endmodule

// File: rtl/fpa_pick.sv
module fpa_pick #(
    parameter int NUM_PIPES = 8,
    parameter int METRIC_W  = 8,
    parameter int NUM_OPS   = 4,
    parameter int IDX_W     = 3,
    parameter int OP_W      = 2
) (
    input  logic [NUM_PIPES*IDX_W-1:0]    order,
    input  logic [NUM_PIPES*METRIC_W-1:0] metrics,
    input  logic [NUM_PIPES-1:0]          busy,
    input  logic [NUM_PIPES*NUM_OPS-1:0]  cap_mask,
    input  logic [OP_W-1:0]               op,
    input  logic                          approx,
    input  logic [METRIC_W-1:0]           thresh,
    output logic                          found,
    output logic [IDX_W-1:0]              idx
);
    // Walk the ranked list; the first eligible candidate wins.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int k = 0; k < NUM_PIPES; k++) begin
            logic [IDX_W-1:0] p;
            logic             ok;
            p  = order[k*IDX_W +: IDX_W];
            ok = !busy[p] && cap_mask[int'(p)*NUM_OPS + int'(op)] &&
                 (!approx || (metrics[int'(p)*METRIC_W +: METRIC_W] < thresh));
            if (!found && ok) begin
                found = 1'b1;
                idx   = p;
            end
        end
    end
endmodule

// File: rtl/fpa_alloc_top.sv
module fpa_alloc_top
    import fpa_pkg::*;
#(
    parameter int NUM_PIPES = 8,
    parameter int METRIC_W  = 8,
    parameter int NUM_OPS   = 4,
    localparam int IDX_W    = (NUM_PIPES > 1) ? $clog2(NUM_PIPES) : 1,
    localparam int OP_W     = (NUM_OPS > 1) ? $clog2(NUM_OPS) : 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          metric_load,
    input  logic [NUM_PIPES*METRIC_W-1:0] metric_in,
    input  logic [NUM_PIPES*NUM_OPS-1:0]  cap_mask,
    input  logic                          req_valid,
    output logic                          req_ready,
    input  logic [OP_W-1:0]               req_op,
    input  logic                          req_approx,
    input  logic [METRIC_W-1:0]           req_thresh,
    output logic                          grant_valid,
    output logic [IDX_W-1:0]              grant_idx,
    input  logic                          release_valid,
    input  logic [IDX_W-1:0]              release_idx,
    output logic [NUM_PIPES-1:0]          pipe_busy,
    output logic [NUM_PIPES-1:0]          pipe_approx
);
    fpa_state_e state_q, state_n;

    logic [NUM_PIPES*METRIC_W-1:0] metric_q;
    logic [NUM_PIPES*IDX_W-1:0]    order_q, order_sorted;
    logic [NUM_PIPES-1:0]          busy_q, mode_q;
    logic                          grant_valid_q;
    logic [IDX_W-1:0]              grant_idx_q;
    logic                          pick_found;
    logic [IDX_W-1:0]              pick_idx;
    logic                          accept;

    function automatic logic [METRIC_W-1:0] metric_of(input logic [IDX_W-1:0] i);
        return metric_q[int'(i)*METRIC_W +: METRIC_W];
    endfunction

    fpa_rank_sort #(
        .NUM_PIPES(NUM_PIPES), .METRIC_W(METRIC_W), .IDX_W(IDX_W)
    ) u_sort (
        .metrics(metric_q),
        .order  (order_sorted)
    );

    fpa_pick #(
        .NUM_PIPES(NUM_PIPES), .METRIC_W(METRIC_W), .NUM_OPS(NUM_OPS),
        .IDX_W(IDX_W), .OP_W(OP_W)
    ) u_pick (
        .order   (order_q),
        .metrics (metric_q),
        .busy    (busy_q),
        .cap_mask(cap_mask),
        .op      (req_op),
        .approx  (req_approx),
        .thresh  (req_thresh),
        .found   (pick_found),
        .idx     (pick_idx)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_EMPTY;
        else        state_q <= state_n;
    end

    // Next-state logic
    always_comb begin
        state_n = state_q;
        if (metric_load) begin
            state_n = S_SORT;                 // load
        end else begin
            unique case (state_q)
                S_EMPTY: state_n = S_EMPTY;   // hold
                S_SORT:  state_n = S_SERVE;   // sorted
                S_SERVE: state_n = S_SERVE;   // hold
                default: state_n = S_EMPTY;
            endcase
        end
    end

    // Outputs
    always_comb begin
        req_ready = 1'b0;
        unique case (state_q)
            S_EMPTY: req_ready = 1'b0;
            S_SORT:  req_ready = 1'b0;
            S_SERVE: req_ready = !metric_load && pick_found;
            default: req_ready = 1'b0;
        endcase
    end

    assign accept = req_valid && req_ready;

    // Datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            metric_q      <= '0;
            order_q       <= '0;
            busy_q        <= '0;
            mode_q        <= '0;
            grant_valid_q <= 1'b0;
            grant_idx_q   <= '0;
        end else begin
            if (metric_load)       metric_q <= metric_in;
            if (state_q == S_SORT) order_q  <= order_sorted;
            if (release_valid)     busy_q[release_idx] <= 1'b0;
            if (accept) begin
                busy_q[pick_idx] <= 1'b1;
                mode_q[pick_idx] <= req_approx;
                grant_idx_q      <= pick_idx;
            end
            grant_valid_q <= accept;
        end
    end

    assign grant_valid = grant_valid_q;
    assign grant_idx   = grant_idx_q;
    assign pipe_busy   = busy_q;
    assign pipe_approx = mode_q;

    // Assertions
    for (genvar k = 0; k < NUM_PIPES - 1; k++) begin : g_rank_chk
        p_rank_ascending_r1: assert property (@(posedge clk) disable iff (!rst_n)
            (state_q == S_SERVE) |->
            (metric_of(order_q[k*IDX_W +: IDX_W]) <= metric_of(order_q[(k+1)*IDX_W +: IDX_W])));
    end

    p_pick_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> !busy_q[pick_idx]);

    p_pick_capable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> cap_mask[int'(pick_idx)*NUM_OPS + int'(req_op)]);

    p_approx_limit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && req_approx) |-> (metric_of(pick_idx) < req_thresh));

    p_grant_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> pipe_busy[grant_idx]);

    p_grant_mode_r6: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (pipe_approx[grant_idx] == $past(req_approx)));

    p_busy_growth_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(busy_q) <= $countones($past(busy_q)) + 1);

    p_ready_serve_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_SERVE) |-> !req_ready);

    p_ready_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
        metric_load |-> !req_ready);
endmodule

// File: tb/test_fpa_alloc_top.sv
module test_fpa_alloc_top;
    localparam int N  = 8;
    localparam int MW = 8;
    localparam int NO = 4;
    localparam int IW = 3;
    localparam int OW = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              metric_load = 1'b0;
    logic [N*MW-1:0]   metric_in = '0;
    logic [N*NO-1:0]   cap_mask = '0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [OW-1:0]     req_op = '0;
    logic              req_approx = 1'b0;
    logic [MW-1:0]     req_thresh = '0;
    logic              grant_valid;
    logic [IW-1:0]     grant_idx;
    logic              release_valid = 1'b0;
    logic [IW-1:0]     release_idx = '0;
    logic [N-1:0]      pipe_busy;
    logic [N-1:0]      pipe_approx;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 0;

    int     m_fig [N];
    logic [N-1:0] busy_m;
    logic [N-1:0] mode_m;

    fpa_alloc_top #(.NUM_PIPES(N), .METRIC_W(MW), .NUM_OPS(NO)) i_fpa_alloc_top (
        .clk(clk), .rst_n(rst_n), .metric_load(metric_load), .metric_in(metric_in),
        .cap_mask(cap_mask), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_approx(req_approx), .req_thresh(req_thresh),
        .grant_valid(grant_valid), .grant_idx(grant_idx),
        .release_valid(release_valid), .release_idx(release_idx),
        .pipe_busy(pipe_busy), .pipe_approx(pipe_approx)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000 && !done) begin
            done = 1;
            errors = errors + 1;
            $display("FAIL watchdog: actual %0d cycles, expected completion", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic bit cap_of(input int p, input int op);
        return (op == 0) || (((p * 3 + op) % 4) != 0);
    endfunction

    // Reference choice: lowest figure among eligible, lower index on ties.
    task automatic exp_pick(input int op, input bit ap, input int thr,
                            output bit found, output int idx);
        found = 0;
        idx = 0;
        for (int p = 0; p < N; p++) begin
            if (!busy_m[p] && cap_of(p, op) && (!ap || m_fig[p] < thr)) begin
                if (!found || m_fig[p] < m_fig[idx]) begin
                    found = 1;
                    idx = p;
                end
            end
        end
    endtask

    task automatic load_set(input int s);
        for (int p = 0; p < N; p++) begin
            case (s)
                0: m_fig[p] = (p * 37 + 11) % 256;
                1: m_fig[p] = 200 - p * 20;
                2: m_fig[p] = 50;
                default: m_fig[p] = (p % 3) * 40;
            endcase
        end
        @(negedge clk);
        for (int p = 0; p < N; p++) metric_in[p*MW +: MW] = MW'(m_fig[p]);
        metric_load = 1;
        req_valid = 1; req_op = 0; req_approx = 0;
        #1 chk(req_ready == 0, "R10 ready during load", req_ready, 0);
        @(negedge clk);
        metric_load = 0;
        #1 chk(req_ready == 0, "R10 ready during ranking", req_ready, 0);
        @(negedge clk);
        req_valid = 0;
    endtask

    task automatic do_req(input int op, input bit ap, input int thr, output bit got);
        bit f; int e;
        exp_pick(op, ap, thr, f, e);
        @(negedge clk);
        req_valid = 1; req_op = OW'(op); req_approx = ap; req_thresh = MW'(thr);
        #1;
        if (f) chk(req_ready == 1, "R2 ready with eligible pipe", req_ready, 1);
        else   chk(req_ready == 0, "R7 no eligible pipe", req_ready, 0);
        @(negedge clk);
        req_valid = 0;
        got = f;
        if (f) begin
            busy_m[e] = 1;
            mode_m[e] = ap;
            chk(grant_valid == 1, "R5 grant strobe", grant_valid, 1);
            if (ap) chk(grant_idx == IW'(e), "R4 approx grant index", grant_idx, e);
            else    chk(grant_idx == IW'(e), "R1 R3 ranked grant index", grant_idx, e);
            chk(pipe_busy == busy_m, "R5 busy vector", pipe_busy, busy_m);
            chk(pipe_approx[e] == ap, "R6 mode of granted pipe", pipe_approx[e], ap);
        end else begin
            chk(grant_valid == 0, "R7 no grant", grant_valid, 0);
        end
    endtask

    task automatic do_release(input int p);
        @(negedge clk);
        release_valid = 1; release_idx = IW'(p);
        @(negedge clk);
        release_valid = 0;
        busy_m[p] = 0;
        chk(pipe_busy == busy_m, "R8 busy after release", pipe_busy, busy_m);
        chk(pipe_approx == mode_m, "R8 modes kept on release", pipe_approx, mode_m);
    endtask

    task automatic release_all();
        for (int p = 0; p < N; p++) if (busy_m[p]) do_release(p);
    endtask

    initial begin
        bit got;
        int thr_list [4] = '{0, 45, 120, 255};
        busy_m = '0;
        mode_m = '0;
        for (int p = 0; p < N; p++)
            for (int op = 0; op < NO; op++)
                cap_mask[p*NO + op] = cap_of(p, op);

        repeat (3) @(negedge clk);
        rst_n = 1;
        req_valid = 1;
        #1;
        chk(pipe_busy == 0, "R9 busy after reset", pipe_busy, 0);
        chk(pipe_approx == 0, "R9 mode after reset", pipe_approx, 0);
        chk(grant_valid == 0, "R9 grant after reset", grant_valid, 0);
        chk(req_ready == 0, "R9 not ready before load", req_ready, 0);
        @(negedge clk);
        chk(grant_valid == 0, "R9 no grant before load", grant_valid, 0);
        req_valid = 0;

        for (int s = 0; s < 4; s++) begin
            load_set(s);
            for (int op = 0; op < NO; op++) begin
                for (int ap = 0; ap < 2; ap++) begin
                    for (int t = 0; t < (ap ? 4 : 1); t++) begin
                        for (int r = 0; r < N + 1; r++) begin
                            do_req(op, ap[0], thr_list[t], got);
                            if (!got) break;
                        end
                        release_all();
                    end
                end
            end
        end

        // R5: strobe lasts one cycle
        do_req(0, 0, 0, got);
        @(negedge clk);
        chk(grant_valid == 0, "R5 grant strobe single cycle", grant_valid, 0);

        // R8: releasing an idle pipe changes nothing
        begin
            int idle;
            idle = 0;
            for (int p = N - 1; p >= 0; p--) if (!busy_m[p]) idle = p;
            do_release(idle);
        end

        // R7: held request waits for a release
        for (int r = 0; r < N; r++) begin
            bit f; int e;
            exp_pick(0, 0, 0, f, e);
            if (f) do_req(0, 0, 0, got);
        end
        @(negedge clk);
        req_valid = 1; req_op = 0; req_approx = 1; req_thresh = 8'd255;
        for (int c = 0; c < 3; c++) begin
            #1 chk(req_ready == 0, "R7 request held while all busy", req_ready, 0);
            @(negedge clk);
        end
        release_valid = 1; release_idx = 3'd5;
        @(negedge clk);
        release_valid = 0;
        busy_m[5] = 0;
        #1 chk(req_ready == (m_fig[5] < 255), "R7 ready after release", req_ready, 1);
        @(negedge clk);
        req_valid = 0;
        chk(grant_valid == 1 && grant_idx == 3'd5, "R7 waiting request granted freed pipe",
            grant_idx, 5);
        chk(pipe_approx[5] == 1, "R6 approx mode set", pipe_approx[5], 1);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule